// File: doc/BRIEF.md
# Center-Aligned Multi-Channel PWM Generator

This block drives several PWM pins from one shared free-running counter. The counter has N+1 active bits, where N is the resolution the caller selects. Its top active bit (bit N) acts as a phase flag rather than as a change in counting direction. While that flag is 0 the channels look for their rising ("up") edge. While it is 1 they look for their falling ("down") edge. Each period is therefore 2^(N+1) enabled clocks long. Each pulse is centred on the counts where the low N counter bits are zero.

Every channel keeps a shadow copy of its compare input. The shadow is refreshed only while reset is held and at the counter wrap, so a value written mid-period never produces a stray edge. A small four-state machine per channel decides its level: `PIN_LOW` and `PIN_HIGH` for normal operation, plus `PIN_HOLD_HI` and `PIN_HOLD_LO` for the compare values that pin the duty at 100 % or 0 %. A per-channel polarity bit inverts the pin after the state machine. The polarity bit is not registered.

Transitions, evaluated only on enabled clocks:
- Any state goes to `PIN_HOLD_HI` when the masked shadow is zero.
- Any state goes to `PIN_HOLD_LO` when the masked shadow is all ones.
- Otherwise, `PIN_LOW` goes to `PIN_HIGH` on an up match.
- Otherwise, `PIN_HIGH` goes to `PIN_LOW` on a down match.
- Otherwise, either hold state goes to `PIN_LOW`.

Top module: `pwm_center_top`

## Requirements
- R1: The counter advances by one only on clocks with `ce` high. It wraps from 2^(N+1)-1 to zero, so the period is 2^(N+1) enabled clocks.
- R2: A clock with `rst` high does three things: it clears the counter, it puts every channel in `PIN_LOW` (pre-inversion level 0), and it loads each shadow from `cmp_in`. During and right after reset, each pin equals its polarity bit.
- R3: On an enabled clock where counter bit N is 1 and the low N counter bits equal the one's complement of the low N shadow bits, a `PIN_HIGH` channel moves to `PIN_LOW`. The change is seen after that edge.
- R4: On an enabled clock where counter bit N is 0 and the low N counter bits equal the low N shadow bits plus one, a `PIN_LOW` channel moves to `PIN_HIGH`.
- R5: A shadow whose low N bits are all zero gives a constant pre-inversion high level (100 %), from the first enabled clock after the shadow is loaded.
- R6: A shadow whose low N bits are all ones gives a constant pre-inversion low level (0 %).
- R7: `pwm_out[i]` is the channel's pre-inversion level XOR `pol[i]`. A change of `pol[i]` shows on the pin in the same cycle.
- R8: Compare bits above bit N-1 have no effect on the pin waveform.
- R9: A shadow changes only under two conditions: on the enabled clock where the counter wraps, or under reset. A new `cmp_in` value has no effect before that point.
- R10: `res_sel` encodes N as follows: 0 gives 8, 1 gives 9, 2 gives 10, 3 gives 11, 4 gives 16, and codes 5 to 7 fall back to 8. For N = 16 the counter has a 17th bit as the phase flag.
- R11: While `ce` is low, the counter and every channel state hold, so with steady `pol` the pins do not move.
- R12: For a masked compare value c strictly between 0 and 2^N-1, the pre-inversion level is high for 2^(N+1) - 2(c+1) clocks of each period.
- R13: A channel that leaves a hold state at the wrap starts the new period in `PIN_LOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Count enable; the block advances only while high |
| res_sel | input | 3 | Resolution code (R10) |
| cmp_in | input | NUM_CH*16 | Compare values; channel i occupies bits 16i+15 to 16i |
| pol | input | NUM_CH | Per-channel output inversion |
| pwm_out | output | NUM_CH | Channel pins |

## Verification
Two things can fall on the same enabled clock: the shadow reload at the counter wrap, and the evaluation of each channel's state machine. On that clock the machine must still use the old shadow, and a change to or from a hold state must appear only on the following clock. The bench provokes this by rewriting `cmp_in` in the middle of a period, including switches between normal values and the forced 0 %/100 % values. It also drops `ce` at random, including on the wrap count. Each pin is judged every cycle against a bench model built from the requirements. Directed duty counts and a mid-period reload check back up that model.

// File: rtl/pwm_center_pkg.sv
package pwm_center_pkg;

    // Widest resolution supported; the counter carries one bit more.
    localparam int MAX_RES = 16;

    // Resolution codes (R10)
    localparam logic [2:0] RES_CODE_8  = 3'd0;
    localparam logic [2:0] RES_CODE_9  = 3'd1;
    localparam logic [2:0] RES_CODE_10 = 3'd2;
    localparam logic [2:0] RES_CODE_11 = 3'd3;
    localparam logic [2:0] RES_CODE_16 = 3'd4;

    typedef enum logic [1:0] {
        PIN_LOW     = 2'd0,
        PIN_HIGH    = 2'd1,
        PIN_HOLD_HI = 2'd2,
        PIN_HOLD_LO = 2'd3
    } pin_state_e;

    function automatic int res_bits(input logic [2:0] code);
        int n;
        unique case (code)
            RES_CODE_9:  n = 9;
            RES_CODE_10: n = 10;
            RES_CODE_11: n = 11;
            RES_CODE_16: n = 16;
            default:     n = 8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pwm_center_timebase.sv
module pwm_center_timebase
    import pwm_center_pkg::*;
#(
    parameter int CW = MAX_RES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic [2:0]    res_sel,
    output logic [CW-1:0] cnt_low,
    output logic [CW-1:0] res_mask,
    output logic          phase,
    output logic          wrap
);

    localparam int TW = CW + 1;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_d;
    logic [TW-1:0] span_mask;
    int            n_bits;

    always_comb begin
        n_bits    = res_bits(res_sel);
        res_mask  = {CW{1'b1}} >> (CW - n_bits);
        span_mask = {res_mask, 1'b1};
    end

    // Bits above the active span are ignored (R8)
    always_comb begin
        cnt_low = cnt_q[CW-1:0] & res_mask;
        phase   = cnt_q[n_bits];
        wrap    = ce && ((cnt_q & span_mask) == span_mask);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (ce) begin
            if (wrap) begin
                cnt_d = '0;
            end else begin
                cnt_d = (cnt_q + 1'b1) & span_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pwm_center_channel.sv
module pwm_center_channel
    import pwm_center_pkg::*;
#(
    parameter int CW = MAX_RES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          wrap,
    input  logic          phase,
    input  logic [CW-1:0] cnt_low,
    input  logic [CW-1:0] res_mask,
    input  logic [CW-1:0] cmp_val,
    input  logic          pol,
    output logic [CW-1:0] shadow,
    output logic          level,
    output logic          pin
);

    pin_state_e    state_q;
    pin_state_e    state_d;
    logic [CW-1:0] cv;
    logic          up_hit;
    logic          down_hit;
    logic          force_hi;
    logic          force_lo;

    // Shadow compare: loaded under reset and at the wrap only (R9)
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            shadow <= cmp_val;
        end
    end

    always_comb begin
        cv       = shadow & res_mask;
        force_hi = (cv == '0);
        force_lo = (cv == res_mask);
        up_hit   = !phase && (cv == ((cnt_low - 1'b1) & res_mask));
        down_hit = phase && (((~cv) & res_mask) == cnt_low);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ce) begin
            if (force_hi) begin
                state_d = PIN_HOLD_HI;
            end else if (force_lo) begin
                state_d = PIN_HOLD_LO;
            end else begin
                unique case (state_q)
                    PIN_LOW:     state_d = up_hit ? PIN_HIGH : PIN_LOW;
                    PIN_HIGH:    state_d = down_hit ? PIN_LOW : PIN_HIGH;
                    PIN_HOLD_HI: state_d = PIN_LOW;
                    PIN_HOLD_LO: state_d = PIN_LOW;
                    default:     state_d = PIN_LOW;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: level before inversion, then polarity (R7)
    always_comb begin
        unique case (state_q)
            PIN_HIGH, PIN_HOLD_HI: level = 1'b1;
            default:               level = 1'b0;
        endcase
        pin = level ^ pol;
    end

endmodule

// File: rtl/pwm_center_top.sv
module pwm_center_top
    import pwm_center_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = MAX_RES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [2:0]           res_sel,
    input  logic [NUM_CH*CW-1:0] cmp_in,
    input  logic [NUM_CH-1:0]    pol,
    output logic [NUM_CH-1:0]    pwm_out
);

    logic [CW-1:0]        cnt_low;
    logic [CW-1:0]        res_mask;
    logic                 phase;
    logic                 wrap;
    logic [NUM_CH-1:0]    pre_out;
    logic [NUM_CH*CW-1:0] shadow_flat;

    pwm_center_timebase #(.CW(CW)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .res_sel  (res_sel),
        .cnt_low  (cnt_low),
        .res_mask (res_mask),
        .phase    (phase),
        .wrap     (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_center_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .ce       (ce),
            .wrap     (wrap),
            .phase    (phase),
            .cnt_low  (cnt_low),
            .res_mask (res_mask),
            .cmp_val  (cmp_in[g*CW +: CW]),
            .pol      (pol[g]),
            .shadow   (shadow_flat[g*CW +: CW]),
            .level    (pre_out[g]),
            .pin      (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_center_chk.sv
module pwm_center_chk #(
    parameter int NUM_CH = 4,
    parameter int CW     = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ce,
    input logic                 wrap,
    input logic                 phase,
    input logic [CW-1:0]        cnt_low,
    input logic [NUM_CH-1:0]    pre_out,
    input logic [NUM_CH*CW-1:0] shadow
);

    assert_reset_low_R2: assert property (@(posedge clk)
        rst |=> (pre_out == '0));

    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ((cnt_low == '0) && !phase));

    assert_ce_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(pre_out) && $stable(cnt_low)));

    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(shadow));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_rise_up_phase_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(pre_out[i]) |-> ($past(ce) && !$past(phase)));

        assert_fall_enabled_R3: assert property (@(posedge clk) disable iff (rst)
            ($fell(pre_out[i]) && !$past(rst)) |-> $past(ce));
    end

endmodule

bind pwm_center_top pwm_center_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .wrap    (wrap),
    .phase   (phase),
    .cnt_low (cnt_low),
    .pre_out (pre_out),
    .shadow  (shadow_flat)
);

// File: tb/pwm_center_top_tb_top.sv
module pwm_center_top_tb_top;

    localparam int NCH = 4;
    localparam int W   = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ce  = 1'b0;
    logic [2:0]       res_sel = 3'd0;
    logic [W-1:0]     cmp_a [NCH];
    logic [NCH-1:0]   pol = '0;
    logic [NCH-1:0]   pwm_out;
    logic [NCH*W-1:0] cmp_flat;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    bit    done = 1'b0;

    // Bench-side model state
    int    m_cnt;
    int    m_sh [NCH];
    int    m_st [NCH];   // 0 low, 1 high, 2 hold high, 3 hold low

    always #10 clk = ~clk;   // 50 MHz

    assign cmp_flat = {cmp_a[3], cmp_a[2], cmp_a[1], cmp_a[0]};

    pwm_center_top #(.NUM_CH(NCH)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .res_sel (res_sel),
        .cmp_in  (cmp_flat),
        .pol     (pol),
        .pwm_out (pwm_out)
    );

    // R10 decode as stated in the requirement
    function automatic int bits_of(input logic [2:0] c);
        case (c)
            3'd1: return 9;
            3'd2: return 10;
            3'd3: return 11;
            3'd4: return 16;
            default: return 8;
        endcase
    endfunction

    // R12 expected pre-inversion high count per period
    function automatic int high_count(input int n, input int c);
        return (1 << (n + 1)) - 2 * (c + 1);
    endfunction

    function automatic logic exp_pin(input int ch);
        logic lv;
        lv = (m_st[ch] == 1) || (m_st[ch] == 2);
        return lv ^ pol[ch];
    endfunction

    // Model built from R1..R6, R9, R11, R13
    always @(posedge clk) begin
        int n, mask, span, ph, lo, cv;
        bit wr;
        n    = bits_of(res_sel);
        mask = (1 << n) - 1;
        span = (1 << (n + 1)) - 1;
        if (rst) begin
            m_cnt = 0;
            for (int c = 0; c < NCH; c++) begin
                m_sh[c] = int'(cmp_a[c]);
                m_st[c] = 0;
            end
        end else if (ce) begin
            wr = ((m_cnt & span) == span);
            ph = (m_cnt >> n) & 1;
            lo = m_cnt & mask;
            for (int c = 0; c < NCH; c++) begin
                cv = m_sh[c] & mask;
                if (cv == 0) m_st[c] = 2;
                else if (cv == mask) m_st[c] = 3;
                else if (m_st[c] == 0) begin
                    if (ph == 0 && cv == ((lo - 1) & mask)) m_st[c] = 1;
                end else if (m_st[c] == 1) begin
                    if (ph == 1 && ((~cv) & mask) == lo) m_st[c] = 0;
                end else m_st[c] = 0;
            end
            m_cnt = wr ? 0 : ((m_cnt + 1) & span);
            if (wr) for (int c = 0; c < NCH; c++) m_sh[c] = int'(cmp_a[c]);
        end
    end

    task automatic check_bit(input string req, input int ch, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual %b expected %b at %0t", req, ch, got, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // One cycle: wait past the edge, compare every pin to the model
    task automatic tick();
        @(posedge clk);
        #3;
        for (int c = 0; c < NCH; c++) check_bit(cur_req, c, pwm_out[c], exp_pin(c));
    endtask

    task automatic do_reset(input logic [2:0] code);
        rst = 1'b1;
        res_sel = code;
        cur_req = "R2";
        tick();
        tick();
        rst = 1'b0;
    endtask

    function automatic logic [W-1:0] rnd_cmp();
        int r;
        r = $urandom % 8;
        case (r)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h00FF;
            3: return 16'h0001;
            default: return W'($urandom);
        endcase
    endfunction

    initial begin : main
        int hi2, hi3;
        void'($urandom(32'h5A17_C3E1));
        cmp_a[0] = 16'h0000;   // R5: forced 100 %
        cmp_a[1] = 16'h12FF;   // R6, R8: low byte all ones -> 0 %
        cmp_a[2] = 16'hAB01;   // R8: junk upper byte, c = 1
        cmp_a[3] = 16'h0040;   // R12 with inversion (R7)
        pol = 4'b1000;

        // R2: pins equal polarity during reset
        do_reset(3'd0);
        ce = 1'b1;

        // R3/R4/R12: duty over one full 8-bit period, plus R5/R6/R8
        cur_req = "R3/R4/R5/R6/R8";
        hi2 = 0;
        hi3 = 0;
        for (int k = 0; k < 512; k++) begin
            tick();
            hi2 += (pwm_out[2] ^ pol[2]);
            hi3 += (pwm_out[3] ^ pol[3]);
        end
        check_int("R12 ch2", hi2, high_count(8, 1));
        check_int("R12/R7 ch3", hi3, high_count(8, 64));

        // R7: polarity flips pins in the same cycle
        cur_req = "R7";
        pol = 4'b0101;
        #1;
        for (int c = 0; c < NCH; c++) check_bit("R7 direct", c, pwm_out[c], exp_pin(c));
        for (int k = 0; k < 100; k++) tick();

        // R9/R13: a mid-period write waits for the wrap
        pol = '0;
        cmp_a[0] = 16'h00FF;
        do_reset(3'd0);
        ce = 1'b1;
        cur_req = "R9";
        for (int k = 0; k < 200; k++) tick();
        cmp_a[0] = 16'h0000;
        for (int k = 0; k < 200; k++) tick();
        check_bit("R9 before wrap", 0, pwm_out[0], 1'b0);
        for (int k = 0; k < 120; k++) tick();
        check_bit("R9 after wrap", 0, pwm_out[0], 1'b1);
        cmp_a[0] = 16'h0003;
        cur_req = "R13";
        for (int k = 0; k < 520; k++) tick();

        // R11: enable low freezes the pins
        cur_req = "R11";
        ce = 1'b0;
        for (int k = 0; k < 40; k++) tick();
        ce = 1'b1;

        // R1/R10 with random enables, compares and polarity, every code
        for (int code = 0; code < 8; code++) begin
            for (int c = 0; c < NCH; c++) cmp_a[c] = rnd_cmp();
            do_reset(3'(code));
            cur_req = "R1/R10/R9/R11";
            for (int k = 0; k < 2500; k++) begin
                ce = ($urandom % 4) != 0;
                if ($urandom % 97 == 0) cmp_a[$urandom % NCH] = rnd_cmp();
                if ($urandom % 211 == 0) pol = NCH'($urandom);
                tick();
            end
        end

        // R10: 16-bit with a 17th phase bit, one full period and a bit
        pol = '0;
        ce = 1'b1;
        cmp_a[0] = 16'h0003;
        cmp_a[1] = 16'hFFFE;
        cmp_a[2] = 16'h8000;
        cmp_a[3] = 16'h0000;
        do_reset(3'd4);
        cur_req = "R10/R1/R3/R4";
        hi2 = 0;
        for (int k = 0; k < 131072; k++) begin
            tick();
            hi2 += pwm_out[0];
        end
        check_int("R12 16-bit ch0", hi2, high_count(16, 3));
        for (int k = 0; k < 300; k++) tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule